// File: doc/BRIEF.md
# SGRAM Command Decoder with Graphics Extensions

This block sits behind the command pins of a two-bank synchronous graphics RAM. On every rising clock edge it samples the active-low strobes (chip select, RAS, CAS, WE), the special-function input `dsf_i`, the address bus and the byte-lane DQM masks. It turns them into one registered operation code for the datapath and array control. Its outputs are:

- the decoded operation and the bank it targets;
- a masked-write flag;
- an illegal-command flag;
- the open-row and write-per-bit state of each bank.

The special-function input changes the meaning of three standard commands:

- Mode-register set becomes special mode-register set.
- Row activate also latches per-bank write-per-bit masking.
- Write becomes block write.

With that input held low the block is a plain SDRAM command decoder.

The block also tracks auto-precharge bursts. While such a burst runs, it rejects any new column command. When the burst ends, it closes the bank that the burst used.

Two mask paths come from DQM. The write-data mask passes through with zero latency. The read-output tri-state enable is pipelined for a read mask latency of two.

Top module: `sgram_cmd_decoder`

## Requirements
- R1: After reset `op_o` is 0 (none), `illegal_o` is 0 and both banks are closed with write-per-bit clear. Commands are encoded as {cs, ras, cas, we}, all active low: 0000 mode set, 0001 refresh, 0010 precharge, 0011 activate, 0100 write, 0101 read, 0110 burst stop, 0111 NOP. A NOP or a cycle with chip select high gives `op_o` = 0 and leaves all bank state unchanged.
- R2: A mode set gives `op_o` = 1 when `dsf_i` is low, and loads the burst-length code from `addr_i[2:0]`. The code values are: 0, 1, 2 and 3 give lengths 1, 2, 4 and 8; 7 gives full page; any other code gives length 1. With `dsf_i` high the mode set gives `op_o` = 2 and leaves the burst-length code unchanged.
- R3: Activate gives `op_o` = 3. It opens the addressed bank and latches that bank's write-per-bit flag from `dsf_i`. The flags appear on `bank_open_o` and `wpb_o`, where bit n belongs to bank n.
- R4: Write gives `op_o` = 5 (normal write) when `dsf_i` is low and `op_o` = 6 (block write) when `dsf_i` is high. `masked_o` equals the write-per-bit flag of the target bank. Read gives `op_o` = 4.
- R5: On activate, read, write and single-bank precharge, `addr_i[10]` selects the bank: low selects bank 0 and high selects bank 1. The selected bank is reported on `op_bank_o`.
- R6: Precharge with `addr_i[9]` low gives `op_o` = 7 and closes only the selected bank. With `addr_i[9]` high it gives `op_o` = 8 and closes both banks, ignoring `addr_i[10]`. A precharge clears the write-per-bit flag of each bank it closes.
- R7: A read or write to a closed bank gives `illegal_o` = 1 and `op_o` = 0, and changes no state.
- R8: Burst stop gives `op_o` = 9 only when the burst-length code is 7 (full page). With any other code it gives `illegal_o` = 1 and `op_o` = 0.
- R9: A legal read or write with `addr_i[9]` high starts an auto-precharge burst that runs for the programmed burst length. While it runs, every read or write, normal or block, gives `illegal_o` = 1. In the last cycle of the burst the bank is closed.
- R10: `din_mask_o` equals `dqm_i` in the same cycle, so the write mask latency is zero.
- R11: DQM sampled at clock edge k appears on `dout_hiz_o` from edge k+1 to edge k+2. An output register that samples at edge k+2 therefore puts its data lanes in high impedance, which gives a read mask latency of two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| dsf_i | input | 1 | Special-function select |
| addr_i | input | 11 | Address; bit 10 selects the bank, bit 9 selects all banks or auto-precharge, bits 2:0 hold the burst code |
| dqm_i | input | 4 | Byte-lane data masks |
| op_o | output | 4 | Registered operation code |
| op_bank_o | output | 1 | Bank targeted by `op_o` |
| masked_o | output | 1 | The reported write uses per-bit masking |
| illegal_o | output | 1 | The command sampled at the last edge was rejected |
| bank_open_o | output | 2 | Open-row flag for each bank |
| wpb_o | output | 2 | Write-per-bit flag for each bank |
| din_mask_o | output | 4 | Write-data lane masks, zero latency |
| dout_hiz_o | output | 4 | Read-output tri-state enables, latency two |

## Verification
The hardest case to reach is the end of an auto-precharge burst. In the final burst cycle, a column command to the other bank must still be rejected, and the burst's own bank must close at that same edge. The stimulus first programs a four-beat burst with a mode set and opens both banks. It then issues a read with auto-precharge and counts edges. It places writes to the other bank at the first and last busy edges and the first free edge, and places NOPs between them so that the bank-open flags can be checked while the burst runs.

// File: rtl/sgram_cmd_pkg.sv
package sgram_cmd_pkg;

  typedef enum logic [3:0] {
    OP_NONE        = 4'd0,
    OP_MRS         = 4'd1,
    OP_SMRS        = 4'd2,
    OP_ACT         = 4'd3,
    OP_READ        = 4'd4,
    OP_WRITE       = 4'd5,
    OP_BLOCK_WRITE = 4'd6,
    OP_PRE         = 4'd7,
    OP_PRE_ALL     = 4'd8,
    OP_BSTOP       = 4'd9,
    OP_REFRESH     = 4'd10
  } sgram_op_e;

  typedef enum logic [2:0] {
    K_NOP, K_MRS, K_REF, K_PRE, K_ACT, K_WRITE, K_READ, K_BSTOP
  } cmd_kind_e;

  localparam logic [2:0] BL_FULL_PAGE = 3'b111;

endpackage

// File: rtl/sgram_cmd_dec.sv
module sgram_cmd_dec
  import sgram_cmd_pkg::*;
(
  input  logic      cs_ni,
  input  logic      ras_ni,
  input  logic      cas_ni,
  input  logic      we_ni,
  output cmd_kind_e kind_o
);

  always_comb begin
    if (cs_ni) begin
      kind_o = K_NOP;
    end else begin
      case ({ras_ni, cas_ni, we_ni})
        3'b000:  kind_o = K_MRS;
        3'b001:  kind_o = K_REF;
        3'b010:  kind_o = K_PRE;
        3'b011:  kind_o = K_ACT;
        3'b100:  kind_o = K_WRITE;
        3'b101:  kind_o = K_READ;
        3'b110:  kind_o = K_BSTOP;
        default: kind_o = K_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sgram_bank_state.sv
module sgram_bank_state #(
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 act_en_i,
  input  logic                 act_bank_i,
  input  logic                 act_wpb_i,
  input  logic [NUM_BANKS-1:0] close_i,
  output logic [NUM_BANKS-1:0] open_o,
  output logic [NUM_BANKS-1:0] wpb_o
);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic hit;
    assign hit = act_en_i && (act_bank_i == 1'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_o[g] <= 1'b0;
        wpb_o[g]  <= 1'b0;
      end else if (hit) begin
        open_o[g] <= 1'b1;
        wpb_o[g]  <= act_wpb_i;
      end else if (close_i[g]) begin
        open_o[g] <= 1'b0;
        wpb_o[g]  <= 1'b0;
      end
    end

    AST_WPB_NEEDS_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wpb_o[g] |-> open_o[g]); // R6
    AST_CLOSE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (close_i[g] && !hit) |=> (!open_o[g] && !wpb_o[g])); // R6
  end

endmodule

// File: rtl/sgram_ap_tracker.sv
module sgram_ap_tracker
  import sgram_cmd_pkg::*;
#(
  parameter int unsigned PAGE_LEN = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       bank_i,
  input  logic [2:0] burst_code_i,
  output logic       busy_o,
  output logic [1:0] close_o
);

  localparam int unsigned CNT_W = $clog2(PAGE_LEN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             bank_q;

  function automatic logic [CNT_W-1:0] burst_len(input logic [2:0] code);
    case (code)
      3'd1:         return CNT_W'(2);
      3'd2:         return CNT_W'(4);
      3'd3:         return CNT_W'(8);
      BL_FULL_PAGE: return CNT_W'(PAGE_LEN);
      default:      return CNT_W'(1);
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bank_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= burst_len(burst_code_i);
      bank_q <= bank_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign busy_o  = (cnt_q != '0);
  assign close_o = (cnt_q == CNT_W'(1)) ? (bank_q ? 2'b10 : 2'b01) : 2'b00;

  AST_AP_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o); // R9

endmodule

// File: rtl/sgram_dqm_pipe.sv
module sgram_dqm_pipe #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned LAT   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] dqm_i,
  output logic [WIDTH-1:0] hiz_o
);

  logic [WIDTH-1:0] stage_q [LAT];

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    stage_q[g] <= '0;
      else if (g == 0) stage_q[g] <= dqm_i;
      else            stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
    end
  end

  assign hiz_o = stage_q[LAT-1];

endmodule

// File: rtl/sgram_cmd_decoder.sv
module sgram_cmd_decoder
  import sgram_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned DQM_W    = 4,
  parameter int unsigned BANK_BIT = 10,
  parameter int unsigned ALL_BIT  = 9,
  parameter int unsigned RD_LAT   = 2,
  parameter int unsigned PAGE_LEN = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic              dsf_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DQM_W-1:0]  dqm_i,
  output logic [3:0]        op_o,
  output logic              op_bank_o,
  output logic              masked_o,
  output logic              illegal_o,
  output logic [1:0]        bank_open_o,
  output logic [1:0]        wpb_o,
  output logic [DQM_W-1:0]  din_mask_o,
  output logic [DQM_W-1:0]  dout_hiz_o
);

  localparam int unsigned NUM_BANKS = 2;

  cmd_kind_e kind;
  sgram_op_e op_d, op_q;
  logic      bank_sel, all_sel, rw, illegal_d, masked_d, bank_d;
  logic      ap_busy, ap_start;
  logic [1:0] ap_close, pre_close, close_mask;
  logic [2:0] burst_code_q;
  logic [ADDR_W-1:0] unused_addr;

  assign unused_addr = addr_i;
  assign bank_sel    = addr_i[BANK_BIT];
  assign all_sel     = addr_i[ALL_BIT];

  sgram_cmd_dec u_dec (
    .cs_ni (cs_ni),
    .ras_ni(ras_ni),
    .cas_ni(cas_ni),
    .we_ni (we_ni),
    .kind_o(kind)
  );

  assign rw = (kind == K_READ) || (kind == K_WRITE);

  // rejection: closed row, running auto-precharge burst, non-page burst stop
  assign illegal_d = (rw && !bank_open_o[bank_sel])
                   || (rw && ap_busy)
                   || ((kind == K_BSTOP) && (burst_code_q != BL_FULL_PAGE));

  always_comb begin
    op_d     = OP_NONE;
    masked_d = 1'b0;
    bank_d   = 1'b0;
    case (kind)
      K_MRS:   op_d = dsf_i ? OP_SMRS : OP_MRS;
      K_REF:   op_d = OP_REFRESH;
      K_ACT:   begin op_d = OP_ACT; bank_d = bank_sel; end
      K_PRE:   begin
                 op_d   = all_sel ? OP_PRE_ALL : OP_PRE;
                 bank_d = all_sel ? 1'b0 : bank_sel;
               end
      K_READ:  begin op_d = OP_READ; bank_d = bank_sel; end
      K_WRITE: begin
                 op_d     = dsf_i ? OP_BLOCK_WRITE : OP_WRITE;
                 masked_d = wpb_o[bank_sel];
                 bank_d   = bank_sel;
               end
      K_BSTOP: op_d = OP_BSTOP;
      default: op_d = OP_NONE;
    endcase
    if (illegal_d) begin
      op_d     = OP_NONE;
      masked_d = 1'b0;
      bank_d   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q         <= OP_NONE;
      op_bank_o    <= 1'b0;
      masked_o     <= 1'b0;
      illegal_o    <= 1'b0;
      burst_code_q <= 3'd0;
    end else begin
      op_q      <= op_d;
      op_bank_o <= bank_d;
      masked_o  <= masked_d;
      illegal_o <= illegal_d;
      if (kind == K_MRS && !dsf_i) burst_code_q <= addr_i[2:0];
    end
  end

  assign op_o = op_q;

  assign pre_close  = (kind != K_PRE) ? 2'b00 :
                      all_sel ? 2'b11 : (bank_sel ? 2'b10 : 2'b01);
  assign close_mask = pre_close | ap_close;
  assign ap_start   = rw && all_sel && !illegal_d;

  sgram_bank_state #(.NUM_BANKS(NUM_BANKS)) u_banks (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_en_i  (kind == K_ACT),
    .act_bank_i(bank_sel),
    .act_wpb_i (dsf_i),
    .close_i   (close_mask),
    .open_o    (bank_open_o),
    .wpb_o     (wpb_o)
  );

  sgram_ap_tracker #(.PAGE_LEN(PAGE_LEN)) u_ap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (ap_start),
    .bank_i      (bank_sel),
    .burst_code_i(burst_code_q),
    .busy_o      (ap_busy),
    .close_o     (ap_close)
  );

  assign din_mask_o = dqm_i;

  sgram_dqm_pipe #(.WIDTH(DQM_W), .LAT(RD_LAT)) u_rd_mask (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .dqm_i (dqm_i),
    .hiz_o (dout_hiz_o)
  );

  AST_RW_BANK_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q inside {OP_READ, OP_WRITE, OP_BLOCK_WRITE}) |->
      (op_bank_o ? $past(bank_open_o[1]) : $past(bank_open_o[0]))); // R7
  AST_BSTOP_FULL_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_BSTOP) |-> ($past(burst_code_q) == BL_FULL_PAGE)); // R8
  AST_PRE_ALL_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_PRE_ALL) |-> (bank_open_o == 2'b00 && wpb_o == 2'b00)); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_q inside {OP_NONE, OP_REFRESH}) && !$past(ap_busy)) |->
      ($stable(bank_open_o) && $stable(wpb_o))); // R1
  AST_MASK_ON_WRITE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    masked_o |-> (op_q inside {OP_WRITE, OP_BLOCK_WRITE})); // R4
  AST_NO_RW_IN_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q inside {OP_READ, OP_WRITE, OP_BLOCK_WRITE}) |-> !$past(ap_busy)); // R9

endmodule

// File: tb/sgram_cmd_decoder_tb.sv
module sgram_cmd_decoder_tb_top;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned WD_CYCLES  = 5000;

  localparam logic [3:0] C_MRS   = 4'b0000;
  localparam logic [3:0] C_PRE   = 4'b0010;
  localparam logic [3:0] C_ACT   = 4'b0011;
  localparam logic [3:0] C_WRITE = 4'b0100;
  localparam logic [3:0] C_READ  = 4'b0101;
  localparam logic [3:0] C_BSTOP = 4'b0110;
  localparam logic [3:0] C_NOP   = 4'b0111;
  localparam logic [3:0] C_DESEL = 4'b1000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b0, ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1;
  logic dsf_i = 1'b0;
  logic [10:0] addr_i = '0;
  logic [3:0]  dqm_i = '0;
  logic [3:0]  op_o;
  logic        op_bank_o, masked_o, illegal_o;
  logic [1:0]  bank_open_o, wpb_o;
  logic [3:0]  din_mask_o, dout_hiz_o;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sgram_cmd_decoder dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .ras_ni(ras_ni),
    .cas_ni(cas_ni), .we_ni(we_ni), .dsf_i(dsf_i), .addr_i(addr_i),
    .dqm_i(dqm_i), .op_o(op_o), .op_bank_o(op_bank_o), .masked_o(masked_o),
    .illegal_o(illegal_o), .bank_open_o(bank_open_o), .wpb_o(wpb_o),
    .din_mask_o(din_mask_o), .dout_hiz_o(dout_hiz_o)
  );

  function automatic logic [10:0] ad(input logic bank, input logic a9, input logic [2:0] lo);
    return {bank, a9, 6'b0, lo};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge sample it, return to NOP
  task automatic issue(input logic [3:0] c, input logic d, input logic [10:0] a);
    {cs_ni, ras_ni, cas_ni, we_ni} = c;
    dsf_i  = d;
    addr_i = a;
    @(negedge clk_i);
    {cs_ni, ras_ni, cas_ni, we_ni} = C_NOP;
    dsf_i  = 1'b0;
    addr_i = '0;
  endtask

  task automatic t_reset;
    check("R1 reset op", op_o, 0);
    check("R1 reset illegal", illegal_o, 0);
    check("R1 reset open", bank_open_o, 2'b00);
    check("R1 reset wpb", wpb_o, 2'b00);
  endtask

  task automatic t_activate;
    issue(C_ACT, 1'b0, ad(0, 0, 0));
    check("R3 act op", op_o, 3);
    check("R5 act bank0", op_bank_o, 0);
    check("R3 open b0", bank_open_o, 2'b01);
    check("R3 wpb off", wpb_o, 2'b00);
    issue(C_ACT, 1'b1, ad(1, 0, 0));
    check("R5 act bank1", op_bank_o, 1);
    check("R3 open both", bank_open_o, 2'b11);
    check("R3 wpb b1", wpb_o, 2'b10);
  endtask

  task automatic t_idle;
    issue(C_DESEL, 1'b1, ad(1, 1, 7));
    check("R1 deselect op", op_o, 0);
    check("R1 deselect illegal", illegal_o, 0);
    check("R1 deselect open", bank_open_o, 2'b11);
    check("R1 deselect wpb", wpb_o, 2'b10);
    issue(C_NOP, 1'b1, ad(0, 1, 0));
    check("R1 nop op", op_o, 0);
    check("R1 nop state", {bank_open_o, wpb_o}, 4'b1110);
  endtask

  task automatic t_mode;
    issue(C_MRS, 1'b0, ad(0, 0, 3));
    check("R2 mrs op", op_o, 1);
    issue(C_MRS, 1'b1, ad(0, 0, 7));
    check("R2 smrs op", op_o, 2);
    issue(C_BSTOP, 1'b0, ad(0, 0, 0));
    check("R2 smrs kept code / R8 bstop illegal", illegal_o, 1);
    check("R8 bstop op none", op_o, 0);
    issue(C_MRS, 1'b0, ad(0, 0, 7));
    issue(C_BSTOP, 1'b0, ad(0, 0, 0));
    check("R8 bstop full page", op_o, 9);
    check("R8 bstop legal", illegal_o, 0);
  endtask

  task automatic t_write;
    issue(C_WRITE, 1'b0, ad(0, 0, 0));
    check("R4 normal write", op_o, 5);
    check("R4 unmasked b0", masked_o, 0);
    issue(C_WRITE, 1'b1, ad(0, 0, 0));
    check("R4 block write", op_o, 6);
    check("R4 block unmasked", masked_o, 0);
    issue(C_WRITE, 1'b0, ad(1, 0, 0));
    check("R4 masked normal", {op_o, masked_o, op_bank_o}, {4'd5, 1'b1, 1'b1});
    issue(C_WRITE, 1'b1, ad(1, 0, 0));
    check("R4 masked block", {op_o, masked_o}, {4'd6, 1'b1});
    issue(C_READ, 1'b0, ad(1, 0, 0));
    check("R4 read", {op_o, op_bank_o, masked_o}, {4'd4, 1'b1, 1'b0});
  endtask

  task automatic t_precharge;
    issue(C_PRE, 1'b0, ad(1, 0, 0));
    check("R6 pre single op", {op_o, op_bank_o}, {4'd7, 1'b1});
    check("R6 pre single state", {bank_open_o, wpb_o}, 4'b0100);
    issue(C_ACT, 1'b1, ad(1, 0, 0));
    check("R3 reopen wpb", wpb_o, 2'b10);
    issue(C_PRE, 1'b0, ad(1, 1, 0));
    check("R6 pre all op", op_o, 8);
    check("R6 pre all state", {bank_open_o, wpb_o}, 4'b0000);
  endtask

  task automatic t_closed;
    issue(C_READ, 1'b0, ad(0, 0, 0));
    check("R7 read closed illegal", {illegal_o, op_o}, {1'b1, 4'd0});
    issue(C_WRITE, 1'b1, ad(1, 0, 0));
    check("R7 write closed illegal", {illegal_o, op_o}, {1'b1, 4'd0});
    check("R7 state unchanged", {bank_open_o, wpb_o}, 4'b0000);
  endtask

  task automatic t_autopre;
    issue(C_ACT, 1'b0, ad(0, 0, 0));
    issue(C_ACT, 1'b1, ad(1, 0, 0));
    issue(C_MRS, 1'b0, ad(0, 0, 2));
    issue(C_READ, 1'b0, ad(0, 1, 0));
    check("R9 ap read accepted", {op_o, illegal_o, op_bank_o}, {4'd4, 1'b0, 1'b0});
    issue(C_WRITE, 1'b0, ad(1, 0, 0));
    check("R9 write in burst", {illegal_o, op_o}, {1'b1, 4'd0});
    issue(C_NOP, 1'b0, ad(0, 0, 0));
    issue(C_NOP, 1'b0, ad(0, 0, 0));
    check("R9 bank held open in burst", bank_open_o, 2'b11);
    issue(C_WRITE, 1'b1, ad(1, 0, 0));
    check("R9 block write last beat", illegal_o, 1);
    check("R9 bank closed at end", bank_open_o, 2'b10);
    issue(C_WRITE, 1'b1, ad(1, 0, 0));
    check("R9 write after burst", {op_o, masked_o, illegal_o}, {4'd6, 1'b1, 1'b0});
    issue(C_READ, 1'b0, ad(0, 0, 0));
    check("R7 read after auto close", illegal_o, 1);
  endtask

  task automatic t_dqm;
    dqm_i = 4'b1010;
    #1;
    check("R10 din mask same cycle", din_mask_o, 4'b1010);
    @(negedge clk_i);
    dqm_i = 4'b0000;
    #1;
    check("R10 din mask follows", din_mask_o, 4'b0000);
    check("R11 hiz not yet", dout_hiz_o, 4'b0000);
    @(negedge clk_i);
    check("R11 hiz at latency", dout_hiz_o, 4'b1010);
    @(negedge clk_i);
    check("R11 hiz released", dout_hiz_o, 4'b0000);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_activate();
    t_idle();
    t_mode();
    t_write();
    t_precharge();
    t_closed();
    t_autopre();
    t_dqm();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule